// File: doc/BRIEF.md
# CAN Controller Reset and Bus-Join Sequencer

This block sequences a CAN controller through a software-requested reset and its later return to the bus. Software asks for reset by writing a two-bit request. When both bits are 1 the controller enters reset at once, even in the middle of a frame. While it is in reset the block holds the transmit line recessive and raises a status flag that software polls before it changes any mode setting. It also issues one-cycle strobes that zero the timestamp counter, the transmit and receive error counters, and the error-passive and bus-off flags. The sinks of those strobes are outside this block.

When software writes both bits back to 0, the block leaves reset and tells the timestamp counter to start. It then watches the receive line at each sample point that an existing bit-timing unit provides. It grants the protocol engine permission to communicate only after it has seen a fixed run of consecutive recessive bits, 11 by default. Any dominant sample restarts the run. A request whose two bits disagree counts as no request, and the block keeps its current state.

Top module: `can_reset_sequencer`

## Requirements
- R1: When rst_req is 2'b11 at a clock edge, in_reset is 1 after that edge. This holds in every state, including while communication is enabled and a frame is in progress.
- R2: ts_clear and err_clear pulse together for exactly one cycle, in the cycle in which in_reset rises from 0 to 1. They do not pulse when a reset request arrives while the block is already in reset.
- R3: tx_out is 1 (recessive) in the same cycle that rst_req becomes 2'b11, before any clock edge, and it stays 1 for as long as in_reset is 1.
- R4: When rst_req is 2'b00 at an edge while in_reset is 1, in_reset is 0 after that edge, and ts_start is 1 for exactly that one cycle.
- R5: After release, comm_enable rises on the edge that samples the IDLE_BITS-th (default 11) consecutive cycle with sample_pt=1 and rx_recessive=1, and not earlier. Cycles with sample_pt=0 neither add to the run nor break it.
- R6: A cycle with sample_pt=1 and rx_recessive=0 during the wait restarts the run from zero, so a further IDLE_BITS recessive samples are needed.
- R7: A request of 2'b01 or 2'b10 changes nothing: in_reset, comm_enable and the run of recessive samples keep their values.
- R8: tx_out equals tx_in while comm_enable is 1 and no reset is being requested. Otherwise tx_out is 1.
- R9: While rst_n is low and after it is released, the block is in reset: in_reset=1, comm_enable=0, ts_clear=err_clear=ts_start=0, and tx_out=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rst_req | input | 2 | Reset request bits from the register interface; 2'b11 enter, 2'b00 leave, other values hold |
| sample_pt | input | 1 | One-cycle pulse at each bit sample point |
| rx_recessive | input | 1 | Sampled receive level, 1 = recessive |
| tx_in | input | 1 | Transmit bit from the protocol engine |
| tx_out | output | 1 | Transmit line toward the bus |
| in_reset | output | 1 | Reset-status flag |
| comm_enable | output | 1 | Permission for the protocol engine to communicate |
| ts_clear | output | 1 | One-cycle strobe that zeroes the timestamp counter |
| err_clear | output | 1 | One-cycle strobe that zeroes the error counters and error-state flags |
| ts_start | output | 1 | One-cycle strobe that starts the timestamp counter |

## Verification
Some properties are checked on every cycle. Entry into reset follows a 2'b11 request, and the transmit line is forced recessive. The clear strobes are single, paired pulses that line up with the rising status flag. Release produces the start strobe. A split request leaves the status unchanged. Permission never rises without a full run of recessive samples, which a checker-side counter tracks.

Other behaviour is shown only by the bench scenarios. These cover the exact edge on which permission rises, a run restarted by a dominant sample part way through, gaps between sample points that must not matter, a reset forced in the middle of a frame, and the outputs during the power-on reset.

// File: rtl/can_rst_pkg.sv
// Package: shared types for the CAN reset/bus-join sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package can_rst_pkg;

    // Sequencer phases: held in reset, waiting for bus idle, communicating.
    typedef enum logic [1:0] {
        ST_RESET  = 2'd0,
        ST_SYNC   = 2'd1,
        ST_ACTIVE = 2'd2
    } seq_state_t;

    // Decoded meaning of the two request bits.
    typedef enum logic [1:0] {
        CMD_HOLD  = 2'd0,
        CMD_ENTER = 2'd1,
        CMD_LEAVE = 2'd2
    } req_cmd_t;

    // Logic level of a recessive bit on the transmit line.
    localparam logic RECESSIVE = 1'b1;

endpackage

// File: rtl/can_rst_req_decode.sv
// Module: can_rst_req_decode
// Turns the two software request bits into a command. Both set means enter
// reset, both clear means leave reset, and a split value means hold.
// Assumes: the request bits are already synchronous to clk.
module can_rst_req_decode
    import can_rst_pkg::*;
(
    input  logic [1:0] req_bits,
    output req_cmd_t   cmd,
    output logic       enter_now
);

    // Classify the request pattern.
    always_comb begin
        unique case (req_bits)
            2'b11:   cmd = CMD_ENTER;
            2'b00:   cmd = CMD_LEAVE;
            default: cmd = CMD_HOLD;
        endcase
    end

    // Combinational enter flag, used to force the line before the next edge.
    always_comb enter_now = (cmd == CMD_ENTER);

endmodule

// File: rtl/can_idle_counter.sv
// Module: can_idle_counter
// Counts consecutive recessive samples while enabled and flags the sample
// that completes a run of IDLE_BITS. Non-sample cycles leave the count alone.
// Assumes: sample_pt is a one-cycle pulse and IDLE_BITS >= 1.
module can_idle_counter #(
    parameter int IDLE_BITS = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic count_en,
    input  logic sample_pt,
    input  logic rx_recessive,
    output logic run_done
);

    localparam int            CNT_W = $clog2(IDLE_BITS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(IDLE_BITS - 1);

    logic [CNT_W-1:0] run_cnt;
    logic             rec_sample;

    // A recessive bit seen at a sample point during the wait.
    always_comb rec_sample = count_en && sample_pt && rx_recessive;

    // The sample that completes the run.
    always_comb run_done = rec_sample && (run_cnt == LAST);

    // Track the length of the current run of recessive samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (!count_en) begin
            run_cnt <= '0;
        end else if (sample_pt) begin
            if (!rx_recessive || run_done)
                run_cnt <= '0;
            else
                run_cnt <= run_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/can_seq_fsm.sv
// Module: can_seq_fsm
// Phase machine for reset, bus-idle wait and active communication, plus the
// registered clear and start strobes that mark phase changes.
// Assumes: cmd comes from can_rst_req_decode; run_done is valid only in sync.
module can_seq_fsm
    import can_rst_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  req_cmd_t cmd,
    input  logic     run_done,
    output logic     in_reset,
    output logic     count_en,
    output logic     comm_enable,
    output logic     clear_pulse,
    output logic     start_pulse
);

    seq_state_t state_q, state_d;

    // Next phase: a reset request wins over everything else.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RESET:  if (cmd == CMD_LEAVE) state_d = ST_SYNC;
            ST_SYNC:   if (cmd == CMD_ENTER) state_d = ST_RESET;
                       else if (run_done)    state_d = ST_ACTIVE;
            ST_ACTIVE: if (cmd == CMD_ENTER) state_d = ST_RESET;
            default:   state_d = ST_RESET;
        endcase
    end

    // Phase register and edge strobes. Power-on leaves the controller in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_RESET;
            clear_pulse <= 1'b0;
            start_pulse <= 1'b0;
        end else begin
            state_q     <= state_d;
            clear_pulse <= (cmd == CMD_ENTER) && (state_q != ST_RESET);
            start_pulse <= (cmd == CMD_LEAVE) && (state_q == ST_RESET);
        end
    end

    // Decode the phase into status and enables.
    always_comb begin
        in_reset    = (state_q == ST_RESET);
        count_en    = (state_q == ST_SYNC);
        comm_enable = (state_q == ST_ACTIVE);
    end

endmodule

// File: rtl/can_reset_sequencer.sv
// Module: can_reset_sequencer (top)
// Sequences software reset and bus re-entry for a CAN controller. It forces
// the transmit line recessive whenever the engine may not drive the bus.
// Assumes: bit timing supplies sample_pt and rx_recessive; synchronous reset.
module can_reset_sequencer
    import can_rst_pkg::*;
#(
    parameter int IDLE_BITS = 11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] rst_req,
    input  logic       sample_pt,
    input  logic       rx_recessive,
    input  logic       tx_in,
    output logic       tx_out,
    output logic       in_reset,
    output logic       comm_enable,
    output logic       ts_clear,
    output logic       err_clear,
    output logic       ts_start
);

    req_cmd_t cmd;
    logic     enter_now;
    logic     count_en;
    logic     run_done;
    logic     clear_pulse;
    logic     start_pulse;
    logic     force_rec;

    can_rst_req_decode u_decode (
        .req_bits  (rst_req),
        .cmd       (cmd),
        .enter_now (enter_now)
    );

    can_idle_counter #(.IDLE_BITS(IDLE_BITS)) u_idle (
        .clk          (clk),
        .rst_n        (rst_n),
        .count_en     (count_en),
        .sample_pt    (sample_pt),
        .rx_recessive (rx_recessive),
        .run_done     (run_done)
    );

    can_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd         (cmd),
        .run_done    (run_done),
        .in_reset    (in_reset),
        .count_en    (count_en),
        .comm_enable (comm_enable),
        .clear_pulse (clear_pulse),
        .start_pulse (start_pulse)
    );

    // Recessive unless communication is allowed and no reset is being asked.
    always_comb force_rec = enter_now || !comm_enable;

    // Drive the bus line.
    always_comb tx_out = force_rec ? RECESSIVE : tx_in;

    // One clear strobe serves both the timestamp and the error state.
    always_comb begin
        ts_clear  = clear_pulse;
        err_clear = clear_pulse;
        ts_start  = start_pulse;
    end

endmodule

// File: rtl/can_reset_sequencer_chk.sv
// Module: can_reset_sequencer_chk
// Property checker bound to can_reset_sequencer. It keeps its own count of
// consecutive recessive samples to bound when permission may rise.
module can_reset_sequencer_chk #(
    parameter int IDLE_BITS = 11
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] rst_req,
    input logic       sample_pt,
    input logic       rx_recessive,
    input logic       tx_in,
    input logic       tx_out,
    input logic       in_reset,
    input logic       comm_enable,
    input logic       ts_clear,
    input logic       err_clear,
    input logic       ts_start
);

    localparam int SEEN_W = $clog2(IDLE_BITS + 2);
    logic [SEEN_W-1:0] seen;

    // Independent tally of the recessive run since the last release or dominant bit.
    always_ff @(posedge clk) begin
        if (!rst_n || in_reset || rst_req == 2'b11)
            seen <= '0;
        else if (sample_pt && !rx_recessive)
            seen <= '0;
        else if (sample_pt && seen != SEEN_W'(IDLE_BITS + 1))
            seen <= seen + 1'b1;
    end

    // R1
    enter_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req == 2'b11) |=> in_reset);

    // R2
    clear_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ts_clear == err_clear);

    // R2
    clear_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ts_clear |=> !ts_clear);

    // R2
    clear_on_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_reset) |-> ts_clear);

    // R3
    tx_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req == 2'b11 || in_reset) |-> tx_out);

    // R4
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_reset && rst_req == 2'b00) |=> (!in_reset && ts_start));

    // R5 R6
    idle_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(comm_enable) |-> (seen >= SEEN_W'(IDLE_BITS)));

    // R7
    split_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req == 2'b01 || rst_req == 2'b10) |=> $stable(in_reset));

    // R8
    tx_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (comm_enable && rst_req != 2'b11) |-> (tx_out == tx_in));

endmodule

bind can_reset_sequencer can_reset_sequencer_chk #(.IDLE_BITS(IDLE_BITS)) u_chk (.*);

// File: tb/can_reset_sequencer_tb.sv
module can_reset_sequencer_tb;

    localparam int IDLE = 11;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] rst_req = 2'b11;
    logic       sample_pt = 1'b0;
    logic       rx_recessive = 1'b1;
    logic       tx_in = 1'b1;
    logic       tx_out, in_reset, comm_enable, ts_clear, err_clear, ts_start;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        string tag;
        logic  rst_e;
        logic  comm_e;
        logic  clr_e;
        logic  start_e;
    } exp_t;

    exp_t sb[$];

    // Bench model of the requirements.
    logic m_reset = 1'b1;
    logic m_comm  = 1'b0;
    int   m_cnt   = 0;

    always #10 clk = ~clk;

    can_reset_sequencer #(.IDLE_BITS(IDLE)) u_dut (
        .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .sample_pt(sample_pt),
        .rx_recessive(rx_recessive), .tx_in(tx_in), .tx_out(tx_out),
        .in_reset(in_reset), .comm_enable(comm_enable), .ts_clear(ts_clear),
        .err_clear(err_clear), .ts_start(ts_start)
    );

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus, check tx at once, queue the post-edge result.
    task automatic drive(input logic [1:0] req, input logic samp, input logic rec,
                         input logic txi, input string tag);
        exp_t e;
        logic nr, nc;
        int   ncnt;
        @(negedge clk);
        rst_req = req; sample_pt = samp; rx_recessive = rec; tx_in = txi;
        #1;
        chk(tag, "tx_out", tx_out, (req == 2'b11 || m_reset || !m_comm) ? 1'b1 : txi);
        nr = m_reset; nc = m_comm; ncnt = m_cnt;
        if (req == 2'b11) begin
            nr = 1'b1; nc = 1'b0; ncnt = 0;
        end else if (m_reset) begin
            if (req == 2'b00) begin nr = 1'b0; ncnt = 0; end
        end else if (!m_comm && samp) begin
            if (!rec) ncnt = 0;
            else if (m_cnt + 1 == IDLE) begin nc = 1'b1; ncnt = 0; end
            else ncnt = m_cnt + 1;
        end
        e.tag = tag; e.rst_e = nr; e.comm_e = nc;
        e.clr_e = nr && !m_reset; e.start_e = m_reset && !nr;
        sb.push_back(e);
        m_reset = nr; m_comm = nc; m_cnt = ncnt;
    endtask

    // Monitor: compare the design against the queued expectation after each edge.
    always @(posedge clk) begin
        #2;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            chk(e.tag, "in_reset",    in_reset,    e.rst_e);
            chk(e.tag, "comm_enable", comm_enable, e.comm_e);
            chk(e.tag, "ts_clear",    ts_clear,    e.clr_e);
            chk(e.tag, "err_clear",   err_clear,   e.clr_e);
            chk(e.tag, "ts_start",    ts_start,    e.start_e);
        end
    end

    task automatic recessive_run(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            drive(2'b00, 1'b1, 1'b1, 1'b0, tag);
            drive(2'b00, 1'b0, 1'b0, 1'b0, tag); // no sample point: dominant level ignored
        end
    endtask

    // Watchdog: a hang counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hang expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R9: outputs during and right after the power-on reset.
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9", "in_reset",    in_reset,    1'b1);
        chk("R9", "comm_enable", comm_enable, 1'b0);
        chk("R9", "ts_clear",    ts_clear,    1'b0);
        chk("R9", "ts_start",    ts_start,    1'b0);
        chk("R9", "tx_out",      tx_out,      1'b1);
        rst_n = 1'b1;
        drive(2'b11, 1'b0, 1'b1, 1'b0, "R2");   // already in reset: no clear strobe
        // R7: split requests in reset change nothing.
        drive(2'b01, 1'b1, 1'b1, 1'b0, "R7");
        drive(2'b10, 1'b1, 1'b1, 1'b0, "R7");
        // R4: release.
        drive(2'b00, 1'b0, 1'b1, 1'b0, "R4");
        // R5: ten recessive samples with gaps, then the eleventh grants access.
        recessive_run(IDLE - 1, "R5");
        drive(2'b00, 1'b1, 1'b1, 1'b0, "R5");
        // R8: transmit passes through.
        drive(2'b00, 1'b0, 1'b1, 1'b0, "R8");
        drive(2'b00, 1'b0, 1'b1, 1'b1, "R8");
        drive(2'b10, 1'b0, 1'b1, 1'b0, "R7");
        // R1 R3: reset mid-frame while driving dominant.
        drive(2'b11, 1'b1, 1'b0, 1'b0, "R1");
        drive(2'b11, 1'b0, 1'b1, 1'b0, "R3");
        drive(2'b00, 1'b0, 1'b1, 1'b0, "R4");
        // R6: six recessive, one dominant, then a fresh run is needed.
        recessive_run(6, "R6");
        drive(2'b00, 1'b1, 1'b0, 1'b0, "R6");
        recessive_run(IDLE - 1, "R6");
        drive(2'b01, 1'b0, 1'b1, 1'b0, "R7");   // split request while waiting
        drive(2'b00, 1'b1, 1'b1, 1'b0, "R6");
        drive(2'b00, 1'b0, 1'b1, 1'b0, "R8");
        // R2: reset during the wait also clears.
        drive(2'b11, 1'b0, 1'b1, 1'b0, "R2");
        drive(2'b00, 1'b0, 1'b1, 1'b0, "R4");
        recessive_run(4, "R5");
        drive(2'b11, 1'b1, 1'b1, 1'b0, "R2");
        drive(2'b11, 1'b0, 1'b1, 1'b0, "R1");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule